// File: doc/BRIEF.md
# Level-Triggered Single-Channel Transfer Sequencer

This block moves one data item at a time from a source address to a destination address. Each move is started by an active-low, level-sensitive request line. Software fills four registers through a small write port: source address, destination address, transfer count and control. Setting the control enable bit together with the level-mode bit opens the channel.

From the first clock edge after the enabling write, the request line is sampled on every edge. A low sample is latched and kept inside the block, and the block raises its bus request. Once the bus grant arrives, the latch is cleared. The block then runs one read cycle at the source address and one write cycle at the destination address. After that it drops the bus request for a release cycle. Samples taken from the grant edge until the end of the write cycle are discarded, so two transfers are always separated by a blackout.

When the count reaches zero, the channel disables itself and raises a done flag.

Top module: `dma_lvl_seq`

## Requirements
- R1: After reset, bus_req_o, rd_o, wr_o and done_o are low and no transfer happens until the channel is programmed.
- R2: A write with reg_sel_i = 0 loads the source address, 1 loads the destination address, 2 loads the count and 3 loads control. Control bit 0 is enable, bit 1 is level mode, bit 2 is the source step and bit 3 is the destination step.
- R3: The request is first sampled on the edge after the edge that captures the enabling control write. A low level seen only on the enabling edge is ignored.
- R4: A low sample taken while acceptance is open is held, even if xfer_req_ni returns high on the next cycle, and it leads to exactly one transfer.
- R5: A held request raises bus_req_o. The read cycle does not start until bus_grant_i is high, and the held request is cleared on the edge where the grant is taken.
- R6: A transfer is one cycle with rd_o high and addr_o equal to the source address. It is followed directly by one cycle with wr_o high and addr_o equal to the destination address.
- R7: The request is ignored on the grant edge, on the edge that ends the read cycle and on the edge that ends the write cycle. It is accepted again on the edge that ends the release cycle. With the request held low and the grant high, the first read appears 3 cycles after the enabling edge, and further reads follow every 5 cycles.
- R8: After each read the source address advances by the source step (0 or 1). After each write the destination address advances by the destination step.
- R9: Every write decrements the count. When the count reaches zero, enable is cleared and done_o rises, and requests are then ignored. Any later control write clears done_o.
- R10: After each write cycle, bus_req_o is low for at least one cycle.
- R11: With enable low or level mode low, no request is accepted and bus_req_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | DW | Register write data |
| xfer_req_ni | input | 1 | Transfer request, active low, level sensitive |
| bus_req_o | output | 1 | Bus request |
| bus_grant_i | input | 1 | Bus grant |
| addr_o | output | DW | Address of the current read or write cycle |
| rd_o | output | 1 | Read cycle strobe |
| wr_o | output | 1 | Write cycle strobe |
| done_o | output | 1 | Programmed count has run out |

## Verification
The assertions assume that software does not rewrite the count register in the same cycle as a write cycle. They also assume that bus_grant_i is only meaningful while bus_req_o is high. The stimulus respects both: it programs registers only while the channel is idle or done, and it only lowers or delays the grant, never withdraws it mid-transfer. The request line is driven freely, including single-cycle low pulses placed on each blackout edge and on the first edge where acceptance reopens.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_READ,
    ST_WRITE,
    ST_REL
  } st_e;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_LVL   = 1;
  localparam int CTRL_SSTEP = 2;
  localparam int CTRL_DSTEP = 3;
endpackage

// File: rtl/dlr_regs.sv
module dlr_regs
  import dlr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          src_adv_i,
  input  logic          dst_adv_i,
  input  logic          cnt_dec_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic          accept_o,
  output logic          done_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] src_q, dst_q, cnt_q;
  logic          en_q, lvl_q, sstep_q, dstep_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      lvl_q   <= 1'b0;
      sstep_q <= 1'b0;
      dstep_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (src_adv_i) src_q <= src_q + {{(DW-1){1'b0}}, sstep_q};
      if (dst_adv_i) dst_q <= dst_q + {{(DW-1){1'b0}}, dstep_q};
      if (cnt_dec_i) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end
      // software write wins over hardware update
      if (we_i) begin
        unique case (sel_e'(sel_i))
          SEL_SRC: src_q <= wdata_i;
          SEL_DST: dst_q <= wdata_i;
          SEL_CNT: cnt_q <= wdata_i;
          SEL_CTRL: begin
            en_q    <= wdata_i[CTRL_EN];
            lvl_q   <= wdata_i[CTRL_LVL];
            sstep_q <= wdata_i[CTRL_SSTEP];
            dstep_q <= wdata_i[CTRL_DSTEP];
            done_q  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign accept_o = en_q && lvl_q && (cnt_q != '0);
  assign done_o   = done_q;

  a_r9_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_i && !we_i) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r9_done_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !en_q);
endmodule

// File: rtl/dlr_req_latch.sv
module dlr_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic req_ni,
  input  logic start_i,
  input  logic blk_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hold_q <= 1'b0;
    else if (start_i || !accept_i)       hold_q <= 1'b0;
    else if (!blk_i && !req_ni)          hold_q <= 1'b1;
  end

  assign hold_o = hold_q;

  a_r5_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !hold_q);
  a_r7_blackout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |=> !hold_q);
  a_r4_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !start_i && accept_i) |=> hold_q);
endmodule

// File: rtl/dlr_fsm.sv
module dlr_fsm
  import dlr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic gnt_i,
  output logic bus_req_o,
  output logic rd_o,
  output logic wr_o,
  output logic start_o,
  output logic blk_o,
  output logic src_adv_o,
  output logic dst_adv_o,
  output logic cnt_dec_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (hold_i) st_d = ST_REQ;
      ST_REQ:   if (!hold_i) st_d = ST_IDLE;
                else if (gnt_i) st_d = ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_REL;
      ST_REL:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign bus_req_o = (st_q == ST_REQ) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign rd_o      = (st_q == ST_READ);
  assign wr_o      = (st_q == ST_WRITE);
  assign start_o   = (st_q == ST_REQ) && hold_i && gnt_i;
  assign blk_o     = rd_o || wr_o;
  assign src_adv_o = rd_o;
  assign dst_adv_o = wr_o;
  assign cnt_dec_o = wr_o;

  a_r6_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);
  a_r6_write_then_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !bus_req_o);
  a_r10_release_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |=> !bus_req_o);
  a_r5_grant_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |-> $past(gnt_i) && $past(bus_req_o));
endmodule

// File: rtl/dma_lvl_seq.sv
module dma_lvl_seq #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          xfer_req_ni,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  output logic [DW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          done_o
);
  logic [DW-1:0] src, dst;
  logic accept, hold, start, blk, src_adv, dst_adv, cnt_dec;

  dlr_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .src_adv_i (src_adv),
    .dst_adv_i (dst_adv),
    .cnt_dec_i (cnt_dec),
    .src_o     (src),
    .dst_o     (dst),
    .accept_o  (accept),
    .done_o    (done_o)
  );

  dlr_req_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .req_ni   (xfer_req_ni),
    .start_i  (start),
    .blk_i    (blk),
    .hold_o   (hold)
  );

  dlr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .gnt_i     (bus_grant_i),
    .bus_req_o (bus_req_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .start_o   (start),
    .blk_o     (blk),
    .src_adv_o (src_adv),
    .dst_adv_o (dst_adv),
    .cnt_dec_o (cnt_dec)
  );

  assign addr_o = rd_o ? src : (wr_o ? dst : '0);

  a_r11_no_bus_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && !bus_req_o) |=> !bus_req_o);
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !bus_req_o) |=> !rd_o);
endmodule

// File: tb/dma_lvl_seq_test.sv
module dma_lvl_seq_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic          req_n = 1'b1;
  logic          gnt = 1'b0;
  logic          bus_req, rd, wr, done;
  logic [DW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int last_rd = -1;
  bit gap_en = 1'b0;
  bit prev_rd = 1'b0;
  bit prev_wr = 1'b0;
  logic [DW-1:0] exp_src = '0, exp_dst = '0;
  int sstep = 0, dstep = 0;

  dma_lvl_seq #(.DW(DW)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .xfer_req_ni (req_n),
    .bus_req_o   (bus_req),
    .bus_grant_i (gnt),
    .addr_o      (addr),
    .rd_o        (rd),
    .wr_o        (wr),
    .done_o      (done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic prog(input logic [DW-1:0] s, input logic [DW-1:0] d, input int n,
                      input int ss, input int ds);
    wreg(2'd0, s);
    wreg(2'd1, d);
    wreg(2'd2, DW'(n));
    exp_src = s; exp_dst = d; sstep = ss; dstep = ds;
    rd_cnt = 0; wr_cnt = 0; last_rd = -1;
  endtask

  // passive monitor: address sequence, read/write pairing, release gap
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (rd) begin
        chk(addr == exp_src, "R8 read address", int'(addr), int'(exp_src));
        exp_src = exp_src + DW'(sstep);
        rd_cnt++;
        if (gap_en && last_rd >= 0)
          chk(cyc - last_rd == 5, "R7 read spacing", cyc - last_rd, 5);
        last_rd = cyc;
      end
      if (wr) begin
        chk(addr == exp_dst, "R8 write address", int'(addr), int'(exp_dst));
        chk(prev_rd, "R6 write follows read", int'(prev_rd), 1);
        exp_dst = exp_dst + DW'(dstep);
        wr_cnt++;
      end
      if (prev_wr) chk(!bus_req, "R10 release after write", int'(bus_req), 0);
      prev_rd = rd;
      prev_wr = wr;
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    steps(3);
    // R1 reset state
    chk(!bus_req && !rd && !wr && !done, "R1 reset outputs",
        int'({bus_req, rd, wr, done}), 0);
    rst_ni = 1'b1;
    req_n = 1'b0;
    gnt = 1'b1;
    steps(5);
    chk(!bus_req && rd_cnt == 0, "R1 idle after reset", rd_cnt, 0);

    // R2 R6 R7 R8 R9 sweep over count and both step bits
    gap_en = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      for (int ss = 0; ss < 2; ss++) begin
        for (int ds = 0; ds < 2; ds++) begin
          req_n = 1'b0;
          prog(DW'(16'h1000 + n * 16'h0100), DW'(16'h8000 + n * 16'h0040), n, ss, ds);
          wreg(2'd3, DW'(ds * 8 + ss * 4 + 3));
          step(); step();
          chk(!rd && bus_req, "R5 bus request before read", int'({bus_req, rd}), 2);
          step();
          chk(rd == 1'b1, "R7 first read 3 cycles after enable", int'(rd), 1);
          steps(5 * n + 10);
          chk(rd_cnt == n, "R9 read count", rd_cnt, n);
          chk(wr_cnt == n, "R9 write count", wr_cnt, n);
          chk(done == 1'b1, "R9 done raised", int'(done), 1);
          chk(exp_src == DW'(16'h1000 + n * 16'h0100 + n * ss), "R2 source step total",
              int'(exp_src), 16'h1000 + n * 16'h0100 + n * ss);
          req_n = 1'b1;
          wreg(2'd3, '0);
          chk(done == 1'b0, "R9 done cleared by control write", int'(done), 0);
        end
      end
    end
    gap_en = 1'b0;

    // R11 level mode off, enable on
    req_n = 1'b0;
    prog(16'h2000, 16'h3000, 2, 1, 1);
    wreg(2'd3, 16'h0001);
    steps(12);
    chk(rd_cnt == 0 && !bus_req, "R11 mode bit low blocks", rd_cnt, 0);
    // R11 enable off, level mode on
    wreg(2'd3, 16'h0002);
    steps(12);
    chk(rd_cnt == 0 && !bus_req, "R11 enable low blocks", rd_cnt, 0);
    req_n = 1'b1;

    // R3 low only on the enabling edge is ignored
    prog(16'h4000, 16'h5000, 4, 1, 1);
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 16'h000F; req_n = 1'b0;
    step();
    reg_we = 1'b0; req_n = 1'b1;
    steps(12);
    chk(rd_cnt == 0, "R3 enabling edge not sampled", rd_cnt, 0);

    // R4 single-cycle pulse is held
    req_n = 1'b0; step(); req_n = 1'b1;
    steps(12);
    chk(rd_cnt == 1, "R4 pulse held to one transfer", rd_cnt, 1);

    // R7 low across read-end and write-end edges is ignored
    req_n = 1'b0; step(); req_n = 1'b1;
    for (int i = 0; i < 10 && !rd; i++) step();
    req_n = 1'b0; step(); step(); req_n = 1'b1;
    steps(12);
    chk(rd_cnt == 2, "R7 blackout read and write edges", rd_cnt, 2);

    // R7 low on the release-end edge is accepted
    req_n = 1'b0; step(); req_n = 1'b1;
    for (int i = 0; i < 10 && !rd; i++) step();
    step(); step();
    req_n = 1'b0; step(); req_n = 1'b1;
    steps(12);
    chk(rd_cnt == 4, "R7 accepted after release", rd_cnt, 4);
    chk(done == 1'b1, "R9 done after last transfer", int'(done), 1);
    req_n = 1'b0; steps(12); req_n = 1'b1;
    chk(rd_cnt == 4 && !bus_req, "R9 requests ignored when done", rd_cnt, 4);

    // R5 waits for grant; grant edge sample is ignored
    gnt = 1'b0;
    prog(16'h6000, 16'h7000, 3, 0, 1);
    wreg(2'd3, 16'h000B);
    req_n = 1'b0; step(); req_n = 1'b1;
    steps(6);
    chk(bus_req && rd_cnt == 0, "R5 held without grant", rd_cnt, 0);
    gnt = 1'b1; req_n = 1'b0; step(); req_n = 1'b1;
    chk(rd == 1'b1, "R5 read after grant", int'(rd), 1);
    steps(12);
    chk(rd_cnt == 1, "R7 grant edge sample ignored", rd_cnt, 1);
    chk(!done, "R9 count not yet exhausted", int'(done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule